// File: doc/BRIEF.md
# Status Pin Function Multiplexer

This block chooses which internal radio status signal appears on one general-purpose output pin. A 4-bit function code selects the source. For some codes the source depends on whether the radio is currently transmitting or receiving. The same code can therefore show a transmit-side event while sending and a receive-side event while listening.

The packet-valid source is shaped in one of two ways. It can be passed through as a level that follows the event. It can also be stretched into a fixed pulse, narrow or wide, counted in system clock cycles. The lengths of both pulses are parameters.

The selected value then goes through an optional inversion and an output-enable stage. A register stage drives both the pin value and the pin enable. All inputs are plain control and status levels; there is no data stream and so no handshake.

Function codes:
- 0: busy (operation in progress) in either state.
- 1: end of access code in TX, frame sync in RX.
- 2: shaped packet-valid.
- 3: transmit data clock in TX, recovered clock in RX.
- 4 to 15: unused.

Top module: `status_pin_mux`

## Requirements
- R1: While reset is asserted and on the first cycle after it, pin_out and pin_oe are 0.
- R2: With code 0 (4'b0000), pin_out shows op_busy one clock after it is sampled, in both the TX state (tx_mode=1) and the RX state (tx_mode=0).
- R3: With code 1 (4'b0001), pin_out shows access_end when tx_mode=1 and frame_sync when tx_mode=0, one clock after sampling.
- R4: With code 2 (4'b0010) and cfg_pulse=0, pin_out follows pkt_valid as a level, one clock after sampling.
- R5: With code 2 and cfg_pulse=1, a rising edge of pkt_valid sampled at clock edge E makes pin_out high from edge E+1 for exactly NARROW_CYC clocks when cfg_wide=0, or WIDE_CYC clocks when cfg_wide=1. The pulse length does not depend on how long pkt_valid stays high.
- R6: A new rising edge of pkt_valid during a pulse restarts the full pulse length from that edge.
- R7: With code 3 (4'b0011), pin_out shows tx_dclk when tx_mode=1 and rx_rclk when tx_mode=0.
- R8: Codes 4 to 15 select logic 0 before inversion, so pin_out is 0 with cfg_inv=0 and 1 with cfg_inv=1.
- R9: When cfg_oe=1, cfg_inv=1 drives the complement of the selected source onto pin_out.
- R10: pin_oe follows cfg_oe one clock later. While pin_oe is 0, pin_out is 0 whatever the value of cfg_inv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = radio in TX state, 0 = RX state |
| op_busy | input | 1 | TX or RX operation in progress |
| access_end | input | 1 | End of access code (TX) |
| frame_sync | input | 1 | Frame sync detected (RX) |
| pkt_valid | input | 1 | Packet-valid event level |
| tx_dclk | input | 1 | Transmit data clock |
| rx_rclk | input | 1 | Receive recovered clock |
| cfg_sel | input | 4 | Function select code |
| cfg_inv | input | 1 | Invert output |
| cfg_oe | input | 1 | Pin output enable |
| cfg_pulse | input | 1 | 1 = pulse shaping for packet-valid, 0 = level |
| cfg_wide | input | 1 | Pulse width select: 0 = narrow, 1 = wide |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |

## Verification
Each direct source, and the enable, reaches the pin one clock after the edge that samples it. A pulse-shaped packet-valid appears one clock later than that, because the edge detector and the pulse counter add a register in front of the output stage.

Inputs are driven just after a falling edge. At the same moment, the bench queues the pin value expected after the next rising edge. A monitor removes one item from the queue shortly after each rising edge and compares it with the pin.

Pulse expectations are written per cycle from the rising-edge index and the pulse length. This covers the exact first and last high cycles, and the restarted window.

// File: rtl/stpin_pkg.sv
`timescale 1ns/1ps
package stpin_pkg;
  typedef enum logic [3:0] {
    FN_BUSY  = 4'd0,
    FN_FRAME = 4'd1,
    FN_VALID = 4'd2,
    FN_CLOCK = 4'd3
  } fn_sel_e;

  typedef struct packed {
    logic [3:0] sel;
    logic       inv;
    logic       oe;
    logic       pulse_mode;
    logic       wide;
  } pin_cfg_t;
endpackage

// File: rtl/stpin_valid_shaper.sv
`timescale 1ns/1ps
module stpin_valid_shaper #(
  parameter int NARROW_CYC = 40,
  parameter int WIDE_CYC   = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  input  logic pulse_mode,
  input  logic wide,
  output logic shaped_out
);
  localparam int MAX_CYC = (WIDE_CYC > NARROW_CYC) ? WIDE_CYC : NARROW_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          evt_prev;
  logic [CW-1:0] remain;
  logic          evt_rise;
  logic [CW-1:0] load_val;

  assign evt_rise = evt_in & ~evt_prev;
  assign load_val = wide ? CW'(WIDE_CYC) : CW'(NARROW_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev <= 1'b0;
      remain   <= '0;
    end else begin
      evt_prev <= evt_in;
      if (evt_rise)
        remain <= load_val;
      else if (remain != '0)
        remain <= remain - CW'(1);
    end
  end

  assign shaped_out = pulse_mode ? (remain != '0) : evt_in;
endmodule

// File: rtl/stpin_func_mux.sv
`timescale 1ns/1ps
module stpin_func_mux
  import stpin_pkg::*;
(
  input  logic [3:0] sel,
  input  logic       tx_mode,
  input  logic       op_busy,
  input  logic       access_end,
  input  logic       frame_sync,
  input  logic       valid_shaped,
  input  logic       tx_dclk,
  input  logic       rx_rclk,
  output logic       raw_out
);
  always_comb begin
    case (sel)
      FN_BUSY:  raw_out = op_busy;
      FN_FRAME: raw_out = tx_mode ? access_end : frame_sync;
      FN_VALID: raw_out = valid_shaped;
      FN_CLOCK: raw_out = tx_mode ? tx_dclk : rx_rclk;
      default:  raw_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/stpin_pad_drive.sv
`timescale 1ns/1ps
module stpin_pad_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic inv,
  input  logic oe,
  output logic pin_out,
  output logic pin_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_out <= oe ? (raw_in ^ inv) : 1'b0;
      pin_oe  <= oe;
    end
  end
endmodule

// File: rtl/status_pin_mux.sv
`timescale 1ns/1ps
module status_pin_mux
  import stpin_pkg::*;
#(
  parameter int NARROW_CYC = 40,
  parameter int WIDE_CYC   = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_mode,
  input  logic       op_busy,
  input  logic       access_end,
  input  logic       frame_sync,
  input  logic       pkt_valid,
  input  logic       tx_dclk,
  input  logic       rx_rclk,
  input  logic [3:0] cfg_sel,
  input  logic       cfg_inv,
  input  logic       cfg_oe,
  input  logic       cfg_pulse,
  input  logic       cfg_wide,
  output logic       pin_out,
  output logic       pin_oe
);
  pin_cfg_t cfg;
  logic     valid_shaped;
  logic     raw_sel;

  assign cfg = '{sel: cfg_sel, inv: cfg_inv, oe: cfg_oe,
                 pulse_mode: cfg_pulse, wide: cfg_wide};

  stpin_valid_shaper #(.NARROW_CYC(NARROW_CYC), .WIDE_CYC(WIDE_CYC)) u_shaper (
    .clk(clk), .rst_n(rst_n), .evt_in(pkt_valid),
    .pulse_mode(cfg.pulse_mode), .wide(cfg.wide), .shaped_out(valid_shaped)
  );

  stpin_func_mux u_mux (
    .sel(cfg.sel), .tx_mode(tx_mode), .op_busy(op_busy),
    .access_end(access_end), .frame_sync(frame_sync),
    .valid_shaped(valid_shaped), .tx_dclk(tx_dclk), .rx_rclk(rx_rclk),
    .raw_out(raw_sel)
  );

  stpin_pad_drive u_pad (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_sel), .inv(cfg.inv),
    .oe(cfg.oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/status_pin_mux_chk.sv
`timescale 1ns/1ps
module status_pin_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cfg_sel,
  input logic       cfg_inv,
  input logic       cfg_oe,
  input logic       cfg_pulse,
  input logic       op_busy,
  input logic       pkt_valid,
  input logic       valid_shaped,
  input logic       pin_out,
  input logic       pin_oe
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_disabled_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);

  assert_oe_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (pin_oe == $past(cfg_oe)));

  assert_busy_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_sel == 4'd0 && cfg_oe && !cfg_inv)) |-> (pin_out == $past(op_busy)));

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_sel >= 4'd4 && cfg_oe && !cfg_inv)) |-> !pin_out);

  assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cfg_pulse && pkt_valid && !$past(pkt_valid)) |=> valid_shaped);
endmodule

bind status_pin_mux status_pin_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_inv(cfg_inv),
  .cfg_oe(cfg_oe), .cfg_pulse(cfg_pulse), .op_busy(op_busy),
  .pkt_valid(pkt_valid), .valid_shaped(valid_shaped),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/status_pin_mux_bench.sv
`timescale 1ns/1ps
module status_pin_mux_bench;
  localparam int N = 5;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_mode = 1'b0, op_busy = 1'b0, access_end = 1'b0, frame_sync = 1'b0;
  logic pkt_valid = 1'b0, tx_dclk = 1'b0, rx_rclk = 1'b0;
  logic [3:0] cfg_sel = 4'd0;
  logic cfg_inv = 1'b0, cfg_oe = 1'b0, cfg_pulse = 1'b0, cfg_wide = 1'b0;
  logic pin_out, pin_oe;

  int n_run = 0;
  int n_fail = 0;
  logic  q_o[$];
  logic  q_oe[$];
  string q_tag[$];

  always #4 clk = ~clk;

  status_pin_mux #(.NARROW_CYC(N), .WIDE_CYC(W)) u_status_pin_mux (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .op_busy(op_busy),
    .access_end(access_end), .frame_sync(frame_sync), .pkt_valid(pkt_valid),
    .tx_dclk(tx_dclk), .rx_rclk(rx_rclk), .cfg_sel(cfg_sel), .cfg_inv(cfg_inv),
    .cfg_oe(cfg_oe), .cfg_pulse(cfg_pulse), .cfg_wide(cfg_wide),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input logic o, input logic oe, input string tag);
    n_run++;
    if (pin_out !== o || pin_oe !== oe) begin
      n_fail++;
      $display("FAIL %s: pin_out=%b pin_oe=%b expected pin_out=%b pin_oe=%b",
               tag, pin_out, pin_oe, o, oe);
    end
  endtask

  // driver: inputs already set at this falling edge; queue the result due next rising edge
  task automatic cyc(input logic o, input logic oe, input string tag);
    q_o.push_back(o);
    q_oe.push_back(oe);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_o.size() > 0) begin
        logic  eo, eoe;
        string t;
        eo = q_o.pop_front();
        eoe = q_oe.pop_front();
        t = q_tag.pop_front();
        check(eo, eoe, t);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cfg_oe = 1'b1; op_busy = 1'b1; cfg_inv = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    cfg_oe = 1'b0;
    @(posedge clk); #2;
    check(1'b0, 1'b0, "R1 after reset");
    @(negedge clk);
    cfg_inv = 1'b0; cfg_oe = 1'b1; op_busy = 1'b0;

    // R2 busy code in both states
    cfg_sel = 4'd0; tx_mode = 1'b1; op_busy = 1'b1; cyc(1, 1, "R2 tx busy high");
    op_busy = 1'b0; cyc(0, 1, "R2 tx busy low");
    tx_mode = 1'b0; op_busy = 1'b1; cyc(1, 1, "R2 rx busy high");
    op_busy = 1'b0; cyc(0, 1, "R2 rx busy low");

    // R3 access end / frame sync
    cfg_sel = 4'd1; tx_mode = 1'b1; access_end = 1'b1; frame_sync = 1'b0; cyc(1, 1, "R3 tx access_end");
    access_end = 1'b0; frame_sync = 1'b1; cyc(0, 1, "R3 tx ignores frame_sync");
    tx_mode = 1'b0; cyc(1, 1, "R3 rx frame_sync");
    frame_sync = 1'b0; access_end = 1'b1; cyc(0, 1, "R3 rx ignores access_end");
    access_end = 1'b0;

    // R7 clocks
    cfg_sel = 4'd3; tx_mode = 1'b1; tx_dclk = 1'b1; rx_rclk = 1'b0; cyc(1, 1, "R7 tx dclk");
    tx_mode = 1'b0; cyc(0, 1, "R7 rx rclk low");
    rx_rclk = 1'b1; tx_dclk = 1'b0; cyc(1, 1, "R7 rx rclk high");
    rx_rclk = 1'b0;

    // R4 level mode
    cfg_sel = 4'd2; cfg_pulse = 1'b0; pkt_valid = 1'b1; cyc(1, 1, "R4 level rise");
    cyc(1, 1, "R4 level hold"); cyc(1, 1, "R4 level hold");
    pkt_valid = 1'b0; cyc(0, 1, "R4 level fall");
    for (int i = 0; i < 12; i++) cyc(0, 1, "R4 idle");

    // R5 narrow pulse, pkt_valid held 3 cycles
    cfg_pulse = 1'b1; cfg_wide = 1'b0;
    for (int i = 0; i <= N + 2; i++) begin
      pkt_valid = (i < 3);
      cyc((i >= 1 && i <= N), 1, "R5 narrow pulse");
    end
    pkt_valid = 1'b0;
    for (int i = 0; i < 3; i++) cyc(0, 1, "R5 idle");

    // R5 wide pulse, pkt_valid held 1 cycle
    cfg_wide = 1'b1;
    for (int i = 0; i <= W + 2; i++) begin
      pkt_valid = (i == 0);
      cyc((i >= 1 && i <= W), 1, "R5 wide pulse");
    end
    pkt_valid = 1'b0;
    for (int i = 0; i < 3; i++) cyc(0, 1, "R5 idle");

    // R6 retrigger with narrow pulse
    cfg_wide = 1'b0;
    for (int i = 0; i <= N + 5; i++) begin
      pkt_valid = (i == 0 || i == 3);
      cyc((i >= 1 && i <= 3 + N), 1, "R6 retrigger");
    end
    pkt_valid = 1'b0;
    cfg_pulse = 1'b0;

    // R8 unused codes, all sources high
    op_busy = 1'b1; access_end = 1'b1; frame_sync = 1'b1; pkt_valid = 1'b1;
    tx_dclk = 1'b1; rx_rclk = 1'b1; tx_mode = 1'b1;
    for (int s = 4; s < 16; s++) begin
      cfg_sel = 4'(s); cfg_inv = 1'b0; cyc(0, 1, "R8 unused code plain");
      cfg_inv = 1'b1; cyc(1, 1, "R8 unused code inverted");
    end

    // R9 inversion of a live source
    cfg_sel = 4'd0; cfg_inv = 1'b1; op_busy = 1'b1; cyc(0, 1, "R9 inv busy high");
    op_busy = 1'b0; cyc(1, 1, "R9 inv busy low");

    // R10 output disable ignores inversion
    cfg_oe = 1'b0; cyc(0, 0, "R10 disabled inv=1");
    op_busy = 1'b1; cfg_inv = 1'b0; cyc(0, 0, "R10 disabled busy=1");
    cfg_oe = 1'b1; cyc(1, 1, "R10 re-enabled");

    while (q_o.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule